// File: doc/BRIEF.md
# Packed-Word Colour Palette Loader

This block is a 256-entry colour lookup table. Each entry holds an 8-bit red, green and blue value. Software loads it through two write ports. A write to the address port selects a group of four entries. Three 32-bit writes to the data port then carry the twelve bytes of that group. The bytes are packed back to back, so an entry can span two words.

The first two data words wait in a staging register. The whole group of four is written on the cycle the third word arrives. After that the group pointer steps to the next four entries, so a full table can be streamed after a single address write. On the pixel side, an 8-bit index returns a 24-bit colour one cycle later. A video-enable input blanks that output to zero.

Top module: `palLoader`

## Requirements
- R1: After reset the address readback is 0, the colour output is 0 and every palette entry reads as 0.
- R2: An address write with a value below 256 sets the group base to that value with bits 1:0 cleared. The new base is visible on `addrRdData` from the next cycle.
- R3: Three data words fill the four entries base+0 to base+3. The bytes are taken in this order: word 0 bits 31:24, 23:16, 15:8, 7:0, then word 1 in the same bit order, then word 2. Byte 3k is the red value of entry k, byte 3k+1 its green value and byte 3k+2 its blue value. On `pixColor`, red is bits 23:16, green bits 15:8 and blue bits 7:0.
- R4: The first and second data words of a group leave the table unchanged.
- R5: A committed group replaces all four entries of that group, whatever they held before.
- R6: An address write with a value of 256 or more is ignored. The base, the word count and any staged words stay as they were.
- R7: A valid address write restarts the word count, so any words already staged are discarded.
- R8: Each commit advances the group base by 4, and the base wraps from 252 to 0.
- R9: `pixColor` shows the entry selected by `pixIndex` one clock after that index is sampled.
- R10: When `videoEn` is low at a clock edge, `pixColor` is 0 after that edge.
- R11: When an address write and a data write arrive in the same cycle, the address write takes effect and the data word is dropped.
- R12: A lookup sampled on the same edge as a commit returns the entry's value from before the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrWrEn | input | 1 | Address write strobe |
| addrWrData | input | 32 | Value written to the address port |
| addrRdData | output | 8 | Current group base, bits 1:0 always zero |
| dataWrEn | input | 1 | Data word write strobe |
| dataWrData | input | 32 | Packed palette data word |
| pixIndex | input | 8 | Pixel index to look up |
| videoEn | input | 1 | Colour output enable; low forces the output to zero |
| pixColor | output | 24 | Looked-up colour, red in bits 23:16 |

## Verification
A wrong group base shows on `addrRdData` in the cycle after the address write or commit that caused it. A wrong word count has no immediate effect at the ports. It shows as a missing or early base step at the next commit, one or two data writes later, and as shifted bytes in the entries that commit writes. A byte placed in the wrong lane, or a staged word that was not cleared, shows on `pixColor` one cycle after the bench looks up the affected entry. For this reason the bench reads back every entry that a test touches, and it runs a long random stream of lookups.

// File: rtl/palPkg.sv
package palPkg;
  localparam int ENTRIES     = 256;
  localparam int COMP_W      = 8;
  localparam int WORD_W      = 32;
  localparam int GROUP       = 4;
  localparam int IDX_W       = $clog2(ENTRIES);
  localparam int COLOR_W     = 3 * COMP_W;
  localparam int GROUP_BITS  = GROUP * COLOR_W;
  localparam int GROUP_WORDS = GROUP_BITS / WORD_W;
  localparam int CNT_W       = $clog2(GROUP_WORDS);
  localparam int GSEL_W      = $clog2(GROUP);

  // Strobes from control to datapath
  typedef struct packed {
    logic             stageLoad;  // store the current word in staging slot wordIdx
    logic [CNT_W-1:0] wordIdx;    // position of the word within its group
    logic             commit;     // last word accepted: write the whole group
    logic [IDX_W-1:0] groupBase;  // first entry of the current group
  } palStrobe_t;
endpackage

// File: rtl/palCtrl.sv
module palCtrl
  import palPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrWrEn,
  input  logic [WORD_W-1:0] addrWrData,
  input  logic              dataWrEn,
  output palStrobe_t        strb
);
  logic [IDX_W-GSEL_W-1:0] groupNum;
  logic [CNT_W-1:0]        wordCnt;
  logic                    addrValid;
  logic                    dataTake;
  logic                    lastWord;

  // An address write always wins over a data write in the same cycle
  assign addrValid = addrWrEn && (addrWrData < WORD_W'(ENTRIES));
  assign dataTake  = dataWrEn && !addrWrEn;
  assign lastWord  = (wordCnt == CNT_W'(GROUP_WORDS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      groupNum <= '0;
      wordCnt  <= '0;
    end else if (addrValid) begin
      groupNum <= addrWrData[IDX_W-1:GSEL_W];
      wordCnt  <= '0;
    end else if (dataTake) begin
      if (lastWord) begin
        wordCnt  <= '0;
        groupNum <= groupNum + 1'b1;  // wraps at the top of the table
      end else begin
        wordCnt  <= wordCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.stageLoad = dataTake && !lastWord;
    strb.wordIdx   = wordCnt;
    strb.commit    = dataTake && lastWord;
    strb.groupBase = {groupNum, {GSEL_W{1'b0}}};
  end
endmodule

// File: rtl/palData.sv
module palData
  import palPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  palStrobe_t         strb,
  input  logic [WORD_W-1:0]  dataWrData,
  input  logic [IDX_W-1:0]   pixIndex,
  input  logic               videoEn,
  output logic [COLOR_W-1:0] pixColor
);
  logic [WORD_W-1:0]     stageWords [GROUP_WORDS-1];
  logic [GROUP_BITS-1:0] groupBus;
  logic [COLOR_W-1:0]    palMem [ENTRIES];

  // Staging slots for every word of the group except the last
  for (genvar w = 0; w < GROUP_WORDS - 1; w++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        stageWords[w] <= '0;
      else if (strb.stageLoad && strb.wordIdx == CNT_W'(w))
        stageWords[w] <= dataWrData;
    end
  end

  // The earliest word sits in the top bits, the live word in the bottom bits
  always_comb begin
    for (int w = 0; w < GROUP_WORDS - 1; w++)
      groupBus[GROUP_BITS-1-w*WORD_W -: WORD_W] = stageWords[w];
    groupBus[WORD_W-1:0] = dataWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++)
        palMem[e] <= '0;
    end else if (strb.commit) begin
      for (int k = 0; k < GROUP; k++)
        palMem[{strb.groupBase[IDX_W-1:GSEL_W], GSEL_W'(k)}] <=
          groupBus[GROUP_BITS-1-k*COLOR_W -: COLOR_W];
    end
  end

  // Registered lookup; reads the table as it stood before this edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pixColor <= '0;
    else
      pixColor <= videoEn ? palMem[pixIndex] : '0;
  end
endmodule

// File: rtl/palLoader.sv
module palLoader
  import palPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               addrWrEn,
  input  logic [WORD_W-1:0]  addrWrData,
  output logic [IDX_W-1:0]   addrRdData,
  input  logic               dataWrEn,
  input  logic [WORD_W-1:0]  dataWrData,
  input  logic [IDX_W-1:0]   pixIndex,
  input  logic               videoEn,
  output logic [COLOR_W-1:0] pixColor
);
  palStrobe_t strb;

  palCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .addrWrEn   (addrWrEn),
    .addrWrData (addrWrData),
    .dataWrEn   (dataWrEn),
    .strb       (strb)
  );

  palData u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .dataWrData (dataWrData),
    .pixIndex   (pixIndex),
    .videoEn    (videoEn),
    .pixColor   (pixColor)
  );

  assign addrRdData = strb.groupBase;
endmodule

// File: rtl/palLoaderChk.sv
module palLoaderChk
  import palPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               addrWrEn,
  input logic [WORD_W-1:0]  addrWrData,
  input logic [IDX_W-1:0]   addrRdData,
  input logic               videoEn,
  input logic [COLOR_W-1:0] pixColor,
  input palStrobe_t         strb
);
  a_r2_base_load: assert property (@(posedge clk) disable iff (!rstN)
    (addrWrEn && addrWrData < WORD_W'(ENTRIES)) |=>
      addrRdData == ($past(addrWrData[IDX_W-1:0]) & ~IDX_W'(GROUP - 1)));

  a_r6_bad_addr_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (addrWrEn && addrWrData >= WORD_W'(ENTRIES)) |=> $stable(addrRdData));

  a_r8_commit_advance: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> addrRdData == $past(addrRdData) + IDX_W'(GROUP));

  a_r10_blank_output: assert property (@(posedge clk) disable iff (!rstN)
    !videoEn |=> pixColor == '0);

  a_r11_addr_wins: assert property (@(posedge clk) disable iff (!rstN)
    addrWrEn |-> (!strb.commit && !strb.stageLoad));
endmodule

bind palLoader palLoaderChk chk (
  .clk        (clk),
  .rstN       (rstN),
  .addrWrEn   (addrWrEn),
  .addrWrData (addrWrData),
  .addrRdData (addrRdData),
  .videoEn    (videoEn),
  .pixColor   (pixColor),
  .strb       (strb)
);

// File: tb/palLoader_test.sv
module palLoader_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrWrEn = 1'b0;
  logic [31:0] addrWrData = '0;
  logic [7:0]  addrRdData;
  logic        dataWrEn = 1'b0;
  logic [31:0] dataWrData = '0;
  logic [7:0]  pixIndex = '0;
  logic        videoEn = 1'b0;
  logic [23:0] pixColor;

  always #2 clk = ~clk;  // 250 MHz

  palLoader uut (
    .clk(clk), .rstN(rstN), .addrWrEn(addrWrEn), .addrWrData(addrWrData),
    .addrRdData(addrRdData), .dataWrEn(dataWrEn), .dataWrData(dataWrData),
    .pixIndex(pixIndex), .videoEn(videoEn), .pixColor(pixColor)
  );

  int    vectors = 0;
  int    errors = 0;
  bit    finished = 1'b0;
  string curReq = "R1";

  // Reference model
  int          modelPal [256];
  int          modelBase;
  int          modelCnt;
  logic [31:0] modelStage [2];
  int          expColor;

  function automatic int byteAt(logic [31:0] w0, logic [31:0] w1, logic [31:0] w2, int j);
    logic [31:0] w;
    w = (j < 4) ? w0 : (j < 8) ? w1 : w2;
    return int'((w >> (24 - 8 * (j % 4))) & 32'hFF);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) modelPal[i] = 0;
      modelBase = 0; modelCnt = 0; expColor = 0;
    end else begin
      expColor = videoEn ? modelPal[pixIndex] : 0;
      if (addrWrEn) begin
        if (addrWrData < 256) begin
          modelBase = int'(addrWrData) & 'hFC;
          modelCnt = 0;
        end
      end else if (dataWrEn) begin
        if (modelCnt < 2) begin
          modelStage[modelCnt] = dataWrData;
          modelCnt++;
        end else begin
          for (int k = 0; k < 4; k++)
            modelPal[modelBase + k] =
              (byteAt(modelStage[0], modelStage[1], dataWrData, 3*k) << 16) |
              (byteAt(modelStage[0], modelStage[1], dataWrData, 3*k+1) << 8) |
               byteAt(modelStage[0], modelStage[1], dataWrData, 3*k+2);
          modelBase = (modelBase + 4) % 256;
          modelCnt = 0;
        end
      end
    end
  end

  task automatic check(string req, string what, int actual, int expected);
    vectors++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, actual, expected);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      check(curReq, "addrRdData", int'(addrRdData), modelBase);
      check(curReq, "pixColor", int'(pixColor), expColor);
    end
  end

  task automatic drive(bit aEn, logic [31:0] aData, bit dEn, logic [31:0] dData);
    @(negedge clk);
    addrWrEn = aEn; addrWrData = aData; dataWrEn = dEn; dataWrData = dData;
  endtask

  task automatic idle();
    drive(0, '0, 0, '0);
  endtask

  task automatic writeGroup(int base, logic [31:0] w0, logic [31:0] w1, logic [31:0] w2);
    drive(1, base, 0, '0);
    drive(0, '0, 1, w0);
    drive(0, '0, 1, w1);
    drive(0, '0, 1, w2);
    idle();
  endtask

  task automatic lookAt(int idx, int expected, string req);
    @(negedge clk);
    addrWrEn = 0; dataWrEn = 0; pixIndex = idx[7:0]; videoEn = 1;
    @(negedge clk);
    check(req, "lookup", int'(pixColor), expected);
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset addr", int'(addrRdData), 0);
    check("R1", "reset color", int'(pixColor), 0);
    rstN = 1'b1;
    lookAt(5, 0, "R1");

    curReq = "R2";
    drive(1, 32'h0B, 0, '0);
    idle();
    check("R2", "base", int'(addrRdData), 8);

    curReq = "R4";
    drive(0, '0, 1, 32'h11223344);
    drive(0, '0, 1, 32'h55667788);
    idle();
    lookAt(9, 0, "R4");
    curReq = "R3";
    drive(0, '0, 1, 32'h99AABBCC);
    idle();
    check("R8", "advance", int'(addrRdData), 12);
    lookAt(8, 'h112233, "R3");
    lookAt(9, 'h445566, "R3");
    lookAt(10, 'h778899, "R3");
    lookAt(11, 'hAABBCC, "R3");

    curReq = "R5";
    writeGroup(8, 32'hA1A2A3B1, 32'hB2B3C1C2, 32'hC3D1D2D3);
    lookAt(8, 'hA1A2A3, "R5");
    lookAt(9, 'hB1B2B3, "R5");
    lookAt(10, 'hC1C2C3, "R5");
    lookAt(11, 'hD1D2D3, "R5");

    curReq = "R7";
    drive(1, 16, 0, '0);
    drive(0, '0, 1, 32'hDEADBEEF);
    drive(1, 16, 0, '0);
    drive(0, '0, 1, 32'h01020304);
    drive(0, '0, 1, 32'h05060708);
    drive(0, '0, 1, 32'h090A0B0C);
    idle();
    lookAt(16, 'h010203, "R7");

    curReq = "R6";
    drive(1, 20, 0, '0);
    drive(0, '0, 1, 32'h21222324);
    drive(1, 300, 0, '0);
    idle();
    check("R6", "base kept", int'(addrRdData), 20);
    drive(0, '0, 1, 32'h25262728);
    drive(0, '0, 1, 32'h292A2B2C);
    idle();
    check("R6", "commit after bad addr", int'(addrRdData), 24);
    lookAt(20, 'h212223, "R6");
    lookAt(23, 'h2A2B2C, "R6");

    curReq = "R8";
    writeGroup(252, 32'h31323334, 32'h35363738, 32'h393A3B3C);
    check("R8", "wrap", int'(addrRdData), 0);
    lookAt(255, 'h3A3B3C, "R8");

    curReq = "R11";
    drive(1, 32, 1, 32'hFFFFFFFF);
    drive(0, '0, 1, 32'h41424344);
    drive(0, '0, 1, 32'h45464748);
    drive(0, '0, 1, 32'h494A4B4C);
    idle();
    lookAt(32, 'h414243, "R11");

    curReq = "R12";
    drive(1, 40, 0, '0);
    drive(0, '0, 1, 32'h51525354);
    drive(0, '0, 1, 32'h55565758);
    drive(0, '0, 1, 32'h595A5B5C);
    pixIndex = 8'd40; videoEn = 1;
    @(negedge clk);
    addrWrEn = 0; dataWrEn = 0;
    check("R12", "old value on commit edge", int'(pixColor), 0);
    lookAt(40, 'h515253, "R12");

    curReq = "R10";
    @(negedge clk);
    pixIndex = 8'd8; videoEn = 0;
    @(negedge clk);
    check("R10", "blanked", int'(pixColor), 0);

    curReq = "R9";
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      addrWrEn   = ($urandom_range(0, 15) == 0);
      addrWrData = $urandom_range(0, 511);
      dataWrEn   = ($urandom_range(0, 3) != 0);
      dataWrData = $urandom;
      pixIndex   = 8'($urandom_range(0, 255));
      videoEn    = ($urandom_range(0, 7) != 0);
    end
    idle();
    @(negedge clk);
    finishRun();
  end
endmodule